// File: doc/BRIEF.md
# Power-On Start-Up Sequencer

This block governs the output pin of a programmable period generator from power-on reset until steady running. After reset it holds the pin low and counts a fixed number of master-clock ticks. It then waits until the configuration code is flagged as valid, and only then lets the divider output through. While it does this it honours the polarity bit and the external reset input in all four combinations.

The polarity bit chooses the convention. With polarity 0, the external reset is active high and the output latch drives the pin directly. With polarity 1, the reset is active low and the latch is inverted at the pin. The output latch changes only on edges of the raw divider output. A reset that is released part way through a divider high phase therefore never produces a shortened pulse: the output resumes at the next rising edge of the divider.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst_n` is low, and after its release until `START_TICKS` (default 500) master ticks have been counted, `out_pin` is 0.
- R2: Clock cycles without `tick` high do not advance the start-up count, and the count stops at `START_TICKS`.
- R3: Once the count is complete, `out_pin` stays 0 for as long as `code_ok` is 0. The sequence continues one clock after `code_ok` is seen high.
- R4: With `pol`=0 and `rst_in`=0 at hand-over, `out_pin` follows `div_out` from the first rising edge of `div_out`, one clock later.
- R5: With `pol`=0 and `rst_in`=1 at hand-over, `out_pin` stays 0 while `div_out` toggles. After release it rises at the next rising edge of `div_out`.
- R6: With `pol`=1, `out_pin` goes to 1 one clock after the code is accepted.
- R7: With `pol`=1 and `rst_in`=1 (inactive), `out_pin` falls at the next master tick and then equals the inverse of `div_out` (latch updated on `div_out` edges).
- R8: With `pol`=1 and `rst_in`=0 (active), `out_pin` stays 1 until release. It then falls at the next rising edge of `div_out`.
- R9: While running, an active reset (`rst_in` XOR `pol` = 1) forces `out_pin` to `pol` one clock later, which truncates a pulse.
- R10: Releasing the reset while `div_out` is high gives no output pulse until `div_out` has fallen and risen again.
- R11: Asserting `rst_n` at any time drives `out_pin` to 0 at once and restarts the full start-up count.
- R12: Changes on `rst_in` during the start-up count have no effect on `out_pin`. Only its level at hand-over counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle master-period strobe |
| code_ok | input | 1 | Configuration code qualified as stable |
| pol | input | 1 | Polarity: 0 reset active high / output direct, 1 reset active low / output inverted |
| rst_in | input | 1 | External output-reset level |
| div_out | input | 1 | Raw divider square wave |
| out_pin | output | 1 | Gated output pin value |

## Verification
The bench sweeps all four combinations of polarity and reset level through a complete start-up. In each run it toggles `rst_in` during the count. A design that sampled the reset too early would show a wrong hand-over level, and one that ignored polarity during settling would never show the high step. Pulses are truncated in the middle of a divider high phase and the reset is then released inside that phase. A latch that followed the level instead of edges would emit a runt pulse there. Long idle stretches without ticks, a late `code_ok`, and a power-on reset in the middle of a run catch counters that run freely, skip the code wait, or fail to restart.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sseq_startcnt.sv
module sseq_startcnt #(
  parameter int START_TICKS = 500,
  localparam int CNT_W = $clog2(START_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(START_TICKS);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == CNT_MAX);
  assign cnt_en = tick && !done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cnt_done,
  input  logic       code_ok,
  input  logic       pol,
  output seq_state_t state_q,
  output logic       settle_exit
);
  seq_state_t state_d;

  assign settle_exit = (state_q == ST_SETTLE) && tick;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:   if (cnt_done) state_d = ST_WAIT;
      ST_WAIT:   if (code_ok)  state_d = pol ? ST_SETTLE : ST_RUN;
      ST_SETTLE: if (tick)     state_d = ST_RUN;
      ST_RUN:                  state_d = ST_RUN;
      default:                 state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sseq_outlatch.sv
module sseq_outlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic settle_exit,
  input  logic rst_act,
  input  logic div_out,
  output logic q_q
);
  logic div_prev_q;
  logic div_edge;
  logic q_d;

  assign div_edge = (div_out != div_prev_q);

  always_comb begin
    q_d = q_q;
    if (settle_exit)      q_d = !rst_act;
    else if (!in_run)     q_d = 1'b0;
    else if (rst_act)     q_d = 1'b0;
    else if (div_edge)    q_d = div_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q        <= 1'b0;
      div_prev_q <= 1'b0;
    end else begin
      q_q        <= q_d;
      div_prev_q <= div_out;
    end
  end
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import sseq_pkg::*;
#(
  parameter int START_TICKS = 500,
  localparam int CNT_W = $clog2(START_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic code_ok,
  input  logic pol,
  input  logic rst_in,
  input  logic div_out,
  output logic out_pin
);
  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;
  logic             settle_exit;
  logic             q_q;
  logic             rst_act;

  assign rst_act = rst_in ^ pol;

  sseq_startcnt #(.START_TICKS(START_TICKS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt_q (cnt_q),
    .done  (cnt_done)
  );

  sseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cnt_done    (cnt_done),
    .code_ok     (code_ok),
    .pol         (pol),
    .state_q     (state_q),
    .settle_exit (settle_exit)
  );

  sseq_outlatch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_run      (state_q == ST_RUN),
    .settle_exit (settle_exit),
    .rst_act     (rst_act),
    .div_out     (div_out),
    .q_q         (q_q)
  );

  always_comb begin
    unique case (state_q)
      ST_RUN:    out_pin = q_q ^ pol;
      ST_SETTLE: out_pin = 1'b1;
      default:   out_pin = 1'b0;
    endcase
  end
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk
  import sseq_pkg::*;
#(
  parameter int START_TICKS = 500,
  localparam int CNT_W = $clog2(START_TICKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             pol,
  input logic             rst_in,
  input logic             div_out,
  input logic             out_pin,
  input seq_state_t       state_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             q_q
);
  a_r1_low_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !out_pin);

  a_r2_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(START_TICKS));

  a_r3_low_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !out_pin);

  a_r6_settle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> out_pin);

  a_r9_reset_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && (rst_in ^ pol)) |=> (out_pin == pol));

  a_r10_rise_on_div_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(q_q) && $past(state_q == ST_RUN)) |-> ($past(div_out) && !$past(div_out, 2)));
endmodule

bind startup_sequencer sseq_chk #(.START_TICKS(START_TICKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .pol     (pol),
  .rst_in  (rst_in),
  .div_out (div_out),
  .out_pin (out_pin),
  .state_q (state_q),
  .cnt_q   (cnt_q),
  .q_q     (q_q)
);

// File: tb/tb_startup_sequencer.sv
`timescale 1ns/1ps
module tb_startup_sequencer;
  localparam int N = 500;

  logic clk = 1'b0;
  logic rst_n, tick, code_ok, pol, rst_in, div_out;
  logic out_pin;
  int   n_run = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  startup_sequencer #(.START_TICKS(N)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .code_ok(code_ok),
    .pol(pol), .rst_in(rst_in), .div_out(div_out), .out_pin(out_pin)
  );

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (out_pin !== exp) begin
      n_fail++;
      $display("FAIL %s: out_pin=%b expected %b", req, out_pin, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0; cyc();
  endtask

  task automatic por(input logic p, input logic r, input logic c);
    rst_n = 1'b0; tick = 1'b0; div_out = 1'b0;
    pol = p; rst_in = r; code_ok = c;
    cyc(3);
    rst_n = 1'b1;
    cyc();
  endtask

  // one complete start-up for a polarity and a reset level at hand-over
  task automatic run_case(input logic p, input logic act);
    logic rin;
    rin = act ^ p;
    por(p, ~rin, 1'b1);
    for (int i = 0; i < N - 1; i++) begin
      rst_in = (i % 2 == 0) ? ~rin : rin;   // R12 toggling during count
      pulse_tick();
    end
    rst_in = rin;
    chk("R1 before last tick", 1'b0);
    pulse_tick();
    cyc();
    if (p) begin
      chk("R6 high after code accepted", 1'b1);
      pulse_tick();
      chk(act ? "R8 held high" : "R7 falls after tick", act ? 1'b1 : 1'b0);
    end else begin
      chk(act ? "R5 held low" : "R12 R4 idle at hand-over", 1'b0);
    end
    for (int k = 0; k < 2; k++) begin
      div_out = 1'b1; cyc();
      chk(act ? "R5 R8 div rise ignored" : "R4 R7 follows div rise", act ? p : ~p);
      div_out = 1'b0; cyc();
      chk(act ? "R5 R8 div fall ignored" : "R4 R7 follows div fall", p);
    end
    if (act) begin
      rst_in = ~rst_in; cyc();
      chk("R5 R8 release waits for edge", p);
      div_out = 1'b1; cyc();
      chk("R5 R8 resumes on rising edge", ~p);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; code_ok = 1'b0; pol = 1'b0; rst_in = 1'b0; div_out = 1'b0;
    cyc(2);
    chk("R1 reset state", 1'b0);

    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++)
        run_case(p[0], a[0]);

    // R3: late code, R2: idle cycles without ticks
    por(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < N - 1; i++) pulse_tick();
    cyc(2000);
    chk("R2 no advance without tick", 1'b0);
    div_out = 1'b1; cyc(); div_out = 1'b0; cyc();
    chk("R1 still low before final tick", 1'b0);
    pulse_tick();
    pulse_tick();
    cyc(20);
    div_out = 1'b1; cyc();
    chk("R3 low without code_ok", 1'b0);
    div_out = 1'b0;
    code_ok = 1'b1; cyc();
    chk("R3 hand-over after code_ok", 1'b0);
    div_out = 1'b1; cyc();
    chk("R4 first pulse after code", 1'b1);

    // R9 truncation, R10 no runt on release
    rst_in = 1'b1; cyc();
    chk("R9 reset truncates pulse", 1'b0);
    rst_in = 1'b0; cyc(3);
    chk("R10 no pulse on release in high phase", 1'b0);
    div_out = 1'b0; cyc();
    chk("R10 still low after fall", 1'b0);
    div_out = 1'b1; cyc();
    chk("R10 pulse at next rising edge", 1'b1);

    // R9 with inverted polarity while running
    pol = 1'b1; rst_in = 1'b1; cyc();
    chk("R9 pol change keeps latch, inverted", 1'b0);
    rst_in = 1'b0; cyc();
    chk("R9 active-low reset forces high", 1'b1);
    pol = 1'b0; rst_in = 1'b0; div_out = 1'b0; cyc();
    div_out = 1'b1; cyc();
    chk("R4 running before power-on reset", 1'b1);

    // R11 power-on reset mid-run
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    chk("R11 immediate low on por", 1'b0);
    cyc(2);
    rst_n = 1'b1; pol = 1'b1; rst_in = 1'b1; code_ok = 1'b1; div_out = 1'b0;
    cyc();
    for (int i = 0; i < N - 1; i++) pulse_tick();
    chk("R11 full count restarted", 1'b0);
    pulse_tick(); cyc();
    chk("R11 R6 high after restart", 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule